// File: doc/BRIEF.md
# Interleaved Bit-Plane Pixel Serializer

This block turns one fetched display byte into a run of output pixel positions. A single byte holds 8, 4 or 2 logical pixels, at 1, 2 or 4 bits per pixel. In the multi-bit depths, the bits of one pixel are not packed side by side. Each pixel's bits are spread across the byte at a fixed stride, so the byte holds one bit-plane per bit of depth. Each logical pixel can be stretched over 1, 2 or 4 output positions. The resulting pixel index goes through a fixed 16-entry palette to a 3-bit RGB colour.

A video fetch engine pulses the load input when a byte has arrived. After that, the position clock enable steps the serializer through exactly one byte's worth of output positions. Once the run is over, the output stays black until the next load. A blanking input forces black during spacing lines without disturbing the position count.

Top module: `pix_serializer`

## Requirements
- R1: After reset, and before any load, `rgb` is 3'b000.
- R2: A clock edge with `load` high captures `din` and starts a new run at position 0, even if a run is already in progress. The first position's colour is visible in the cycle after that edge.
- R3: With depth code 2'b00 (1 bit per pixel), logical pixel k (k = 0..7) is byte bit 7−k, so bit 7 comes out first.
- R4: With depth code 2'b01 (2 bits per pixel), logical pixel k (k = 0..3) takes its high bit from byte bit 7−k and its low bit from byte bit 3−k.
- R5: With depth code 2'b10 (4 bits per pixel), logical pixel k (k = 0,1) takes index bits 3,2,1,0 from byte bits 7−k, 5−k, 3−k and 1−k.
- R6: The scale code sets the stretch factor. 2'b00 repeats each pixel once, 2'b01 twice, 2'b10 four times, and 2'b11 once. Position p shows logical pixel floor(p / factor).
- R7: A run lasts exactly 8 advancing positions. After the 8th advance, `rgb` is 3'b000 until the next load.
- R8: A cycle with `pos_en` low and `load` low does not move the position, so `rgb` holds its colour.
- R9: While `blank` is high, `rgb` is 3'b000, but positions keep advancing, so the run ends at the same cycle as an unblanked run.
- R10: The palette maps index i to colour i mod 8, with red on `rgb[0]`, green on `rgb[1]` and blue on `rgb[2]`. Depth code 2'b11 behaves as 1 bit per pixel.
- R11: When the stretch factor times the pixel count is below 8, the logical pixel index wraps modulo the pixel count. For example, 4 bits per pixel at factor 1 gives pixels 0,1,0,1,...

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture `din` and restart the run |
| din | input | 8 | Fetched display byte |
| depth_sel | input | 2 | Bits per pixel: 00=1, 01=2, 10=4, 11=1 |
| scale_sel | input | 2 | Stretch: 00=x1, 01=x2, 10=x4, 11=x1 |
| blank | input | 1 | Force black output |
| pos_en | input | 1 | Advance one output position |
| rgb | output | 3 | Pixel colour, red in bit 0 |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, a deepest mode of 4 bits per pixel and a 3-bit colour. These values bring every depth code and every scale code within reach, including the reserved codes. They also cover the wrap case where a 2-pixel byte is stretched only once over 8 positions, and indices above 7 that show the palette folding. Test bytes are built by an inverse-interleave encoder from known pixel lists, so each depth's bit-plane layout is checked against pixel values rather than raw bits. Stalls of the position enable, blanking windows and reloads in the middle of a run are driven on top of this.

// File: rtl/pix_pkg.sv
package pix_pkg;
   // Depth select codes (reserved code falls back to one bit per pixel)
   typedef enum logic [1:0] {
      DEPTH_1   = 2'b00,
      DEPTH_2   = 2'b01,
      DEPTH_4   = 2'b10,
      DEPTH_RSV = 2'b11
   } depth_e;

   // Scale select codes (reserved code falls back to no stretch)
   typedef enum logic [1:0] {
      SCALE_X1  = 2'b00,
      SCALE_X2  = 2'b01,
      SCALE_X4  = 2'b10,
      SCALE_RSV = 2'b11
   } scale_e;

   // Number of position bits to drop for a given scale code
   function automatic int unsigned scale_shift(input logic [1:0] code);
      case (code)
         SCALE_X2: return 1;
         SCALE_X4: return 2;
         default:  return 0;
      endcase
   endfunction
endpackage

// File: rtl/pix_sequencer.sv
module pix_sequencer #(
   parameter int unsigned SLOTS = 8,
   localparam int unsigned POS_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             pos_en,
   output logic             active,
   output logic [POS_W-1:0] pos
);
   localparam logic [POS_W-1:0] LAST = POS_W'(SLOTS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         pos    <= '0;
      end else if (load) begin
         active <= 1'b1;
         pos    <= '0;
      end else if (active && pos_en) begin
         if (pos == LAST) begin
            active <= 1'b0;
            pos    <= '0;
         end else begin
            pos <= pos + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pix_extract.sv
module pix_extract
   import pix_pkg::*;
#(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned MAX_BPP = 4,
   localparam int unsigned POS_W  = $clog2(BYTE_W),
   localparam int unsigned N_DEP  = $clog2(MAX_BPP) + 1
) (
   input  logic [BYTE_W-1:0]  data,
   input  logic [1:0]         depth_sel,
   input  logic [1:0]         scale_sel,
   input  logic [POS_W-1:0]   pos,
   output logic [MAX_BPP-1:0] idx
);
   logic [MAX_BPP-1:0] lanes [N_DEP];
   logic [POS_W-1:0]   lpos;

   // Logical pixel number before the per-depth wrap
   always_comb begin
      lpos = pos >> scale_shift(scale_sel);
   end

   // One decoder per depth: depth d carries 2**d bit-planes
   for (genvar d = 0; d < N_DEP; d++) begin : g_depth
      localparam int unsigned BPP  = 1 << d;
      localparam int unsigned NPIX = BYTE_W / BPP;
      logic [MAX_BPP-1:0] lane_v;
      always_comb begin
         int unsigned k;
         k = int'(lpos) & (NPIX - 1);
         lane_v = '0;
         for (int j = 0; j < BPP; j++) begin
            lane_v[j] = data[j*NPIX + (NPIX - 1) - k];
         end
      end
      assign lanes[d] = lane_v;
   end

   always_comb begin
      idx = lanes[0];
      for (int d = 1; d < N_DEP; d++) begin
         if (int'(depth_sel) == d) idx = lanes[d];
      end
   end
endmodule

// File: rtl/pix_palette.sv
module pix_palette #(
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned COLOR_W = 3,
   localparam int unsigned ENTRIES = 1 << IDX_W
) (
   input  logic [IDX_W-1:0]   idx,
   output logic [COLOR_W-1:0] color
);
   logic [COLOR_W-1:0] table_q [ENTRIES];

   // Fixed map: index folds onto the colour range
   for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
      assign table_q[i] = COLOR_W'(i % (1 << COLOR_W));
   end

   assign color = table_q[idx];
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
   import pix_pkg::*;
#(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned MAX_BPP = 4,
   parameter int unsigned COLOR_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [BYTE_W-1:0]  din,
   input  logic [1:0]         depth_sel,
   input  logic [1:0]         scale_sel,
   input  logic               blank,
   input  logic               pos_en,
   output logic [COLOR_W-1:0] rgb
);
   localparam int unsigned POS_W = $clog2(BYTE_W);

   // Elaboration-time parameter checks
   if (BYTE_W < 4 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_byte
      $error("BYTE_W must be a power of two of at least 4");
   end
   if (MAX_BPP < 1 || MAX_BPP > BYTE_W / 2 || (MAX_BPP & (MAX_BPP - 1)) != 0) begin : g_bad_bpp
      $error("MAX_BPP must be a power of two no larger than BYTE_W/2");
   end
   if (COLOR_W < 1 || COLOR_W > MAX_BPP) begin : g_bad_color
      $error("COLOR_W must lie between 1 and MAX_BPP");
   end

   logic [BYTE_W-1:0]  byte_q;
   logic               active;
   logic [POS_W-1:0]   pos;
   logic [MAX_BPP-1:0] idx;
   logic [COLOR_W-1:0] pal_rgb;

   always_ff @(posedge clk) begin
      if (!rst_n)    byte_q <= '0;
      else if (load) byte_q <= din;
   end

   pix_sequencer #(.SLOTS(BYTE_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .pos_en (pos_en),
      .active (active),
      .pos    (pos)
   );

   pix_extract #(.BYTE_W(BYTE_W), .MAX_BPP(MAX_BPP)) u_ext (
      .data      (byte_q),
      .depth_sel (depth_sel),
      .scale_sel (scale_sel),
      .pos       (pos),
      .idx       (idx)
   );

   pix_palette #(.IDX_W(MAX_BPP), .COLOR_W(COLOR_W)) u_pal (
      .idx   (idx),
      .color (pal_rgb)
   );

   assign rgb = (active && !blank) ? pal_rgb : '0;
endmodule

// File: rtl/pix_serializer_chk.sv
module pix_serializer_chk #(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned COLOR_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               load,
   input logic [BYTE_W-1:0]  din,
   input logic [1:0]         depth_sel,
   input logic [1:0]         scale_sel,
   input logic               blank,
   input logic               pos_en,
   input logic [COLOR_W-1:0] rgb
);
   localparam int unsigned CW = $clog2(BYTE_W) + 1;
   logic          armed;
   logic [CW-1:0] seen;

   // Independent count of advancing positions since the last load
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         seen  <= '0;
      end else if (load) begin
         armed <= 1'b1;
         seen  <= '0;
      end else if (armed && pos_en) begin
         if (seen == CW'(BYTE_W - 1)) armed <= 1'b0;
         seen <= seen + 1'b1;
      end
   end

   // R1 and R7: no run in progress means black
   assert_idle_black_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> rgb == '0);

   assert_blank_black_R9: assert property (@(posedge clk) disable iff (!rst_n)
      blank |-> rgb == '0);

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pos_en && !load) |=> (!$stable(blank) || !$stable(depth_sel) ||
                              !$stable(scale_sel) || $stable(rgb)));

   assert_first_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (blank || depth_sel != 2'b00 ||
                rgb == COLOR_W'($past(din[BYTE_W-1]))));
endmodule

bind pix_serializer pix_serializer_chk #(.BYTE_W(BYTE_W), .COLOR_W(COLOR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load      (load),
   .din       (din),
   .depth_sel (depth_sel),
   .scale_sel (scale_sel),
   .blank     (blank),
   .pos_en    (pos_en),
   .rgb       (rgb)
);

// File: tb/test_pix_serializer.sv
module test_pix_serializer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load = 1'b0;
   logic [7:0] din = '0;
   logic [1:0] depth_sel = '0;
   logic [1:0] scale_sel = '0;
   logic       blank = 1'b0;
   logic       pos_en = 1'b1;
   logic [2:0] rgb;

   int n_cmp = 0;
   int n_bad = 0;
   logic sample = 1'b0;
   logic [2:0] exp_q [$];
   string      tag_q [$];

   always #5 clk = ~clk;

   pix_serializer i_pix_serializer (
      .clk(clk), .rst_n(rst_n), .load(load), .din(din),
      .depth_sel(depth_sel), .scale_sel(scale_sel), .blank(blank),
      .pos_en(pos_en), .rgb(rgb)
   );

   task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: rgb=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Monitor: compares each sampled position with the scoreboard head
   always @(negedge clk) begin
      if (sample) begin
         if (exp_q.size() == 0) begin
            check(rgb, 3'bxxx, "scoreboard underflow");
         end else begin
            check(rgb, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   // Inverse interleave: pixel k of pix sits in nibble k
   function automatic logic [7:0] encode(input int bpp, input logic [31:0] pix);
      int r = 0;
      for (int k = 0; k < 8 / bpp; k++) begin
         int v = int'(pix[4*k +: 4]);
         if (bpp == 1)      r = (r << 1) | (v & 1);
         else if (bpp == 2) r = (r << 1) | ((v & 2) << 3) | (v & 1);
         else               r = (r << 1) | ((v & 8) << 3) | ((v & 4) << 2) | ((v & 2) << 1) | (v & 1);
      end
      return r[7:0];
   endfunction

   // Driver: push the expected colours, then load and run 8 positions plus one idle
   task automatic run_byte(input logic [1:0] dcode, input logic [1:0] scode,
                           input logic [31:0] pix, input logic [7:0] bmask, input string tag);
      int bpp = (dcode == 2'b01) ? 2 : (dcode == 2'b10) ? 4 : 1;
      int sh  = (scode == 2'b01) ? 1 : (scode == 2'b10) ? 2 : 0;
      int np  = 8 / bpp;
      for (int p = 0; p < 8; p++) begin
         int ix = int'(pix[4*((p >> sh) % np) +: 4]);
         exp_q.push_back(bmask[p] ? 3'd0 : 3'(ix % 8));
         tag_q.push_back($sformatf("%s pos%0d", tag, p));
      end
      exp_q.push_back(3'd0);
      tag_q.push_back($sformatf("%s idle R7", tag));
      @(posedge clk); #1;
      depth_sel = dcode; scale_sel = scode; pos_en = 1'b1;
      din = encode(bpp, pix); load = 1'b1;
      for (int p = 0; p < 9; p++) begin
         @(posedge clk); #1;
         load = 1'b0;
         blank = (p < 8) ? bmask[p] : 1'b0;
         sample = 1'b1;
      end
      @(posedge clk); #1;
      sample = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); check(rgb, 3'd0, "R1 reset black");
      repeat (2) @(posedge clk);
      @(negedge clk); check(rgb, 3'd0, "R1 no load yet");

      run_byte(2'b00, 2'b00, 32'h1011_0010, 8'h00, "R3 1bpp msb first");
      run_byte(2'b01, 2'b01, 32'h0000_1203, 8'h00, "R4 2bpp interleave R6 x2");
      run_byte(2'b10, 2'b10, 32'h0000_006D, 8'h00, "R5 4bpp interleave R6 x4 R10 fold");
      run_byte(2'b10, 2'b00, 32'h0000_00F9, 8'h00, "R11 4bpp wrap");
      run_byte(2'b01, 2'b00, 32'h0000_2130, 8'h00, "R11 2bpp wrap");
      run_byte(2'b00, 2'b01, 32'h0110_1001, 8'h00, "R6 1bpp x2");
      run_byte(2'b11, 2'b11, 32'h1100_0101, 8'h00, "R10 reserved depth R6 reserved scale");
      run_byte(2'b10, 2'b01, 32'h0000_0037, 8'h3C, "R9 blank window");

      // R8: stall with pos_en low keeps position 0
      @(posedge clk); #1;
      depth_sel = 2'b00; scale_sel = 2'b00; din = 8'h81; load = 1'b1; pos_en = 1'b0;
      @(posedge clk); #1 load = 1'b0;
      @(negedge clk); check(rgb, 3'd1, "R8 stall pos0");
      repeat (2) begin
         @(posedge clk); @(negedge clk); check(rgb, 3'd1, "R8 still pos0");
      end
      @(posedge clk); #1 pos_en = 1'b1;
      @(posedge clk); @(negedge clk); check(rgb, 3'd0, "R8 advanced pos1");
      repeat (6) @(posedge clk);
      @(negedge clk); check(rgb, 3'd1, "R7 last pos7");
      @(posedge clk); @(negedge clk); check(rgb, 3'd0, "R7 ended");

      // R2: reload in mid-run restarts at position 0
      @(posedge clk); #1;
      din = 8'h0F; load = 1'b1;
      @(posedge clk); #1 load = 1'b0;
      @(negedge clk); check(rgb, 3'd0, "R2 first byte pos0");
      @(posedge clk); #1 din = 8'hF0; load = 1'b1;
      @(negedge clk); check(rgb, 3'd0, "R2 first byte pos1");
      @(posedge clk); #1 load = 1'b0;
      @(negedge clk); check(rgb, 3'd1, "R2 restart pos0");
      repeat (3) @(posedge clk);
      @(negedge clk); check(rgb, 3'd1, "R2 restart pos3");
      @(posedge clk); @(negedge clk); check(rgb, 3'd0, "R2 restart pos4");
      repeat (4) @(posedge clk);
      @(negedge clk); check(rgb, 3'd0, "R7 restart ended");

      if (exp_q.size() != 0) check(3'd0, 3'd1, "scoreboard leftover");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule